// File: doc/BRIEF.md
# Byte Alignment Unit

This unit provides two cooperating alignment operations for unaligned block copies. The align-address operation adds two 64-bit operands. It returns the sum rounded down to an 8-byte boundary and keeps the byte offset that was discarded in a small status register. A later extract operation reads that offset. It treats its two 64-bit operands as one 16-byte stream, with the first operand supplying the earlier bytes. It returns the 8 bytes that start at the kept offset.

A copy loop issues one align-address to set up the load address and the offset. It then issues a series of extract operations, one per pair of aligned words. The extract never takes an explicit shift amount; the status register supplies it. A test port can load the whole status register and read it back, so that any offset can be set directly.

Top module: `byte_align_unit`

## Requirements
- R1: An align-address operation (`in_op` = 0) returns the 64-bit sum of `in_a` and `in_b`, wrapped modulo 2^64, with bits 2:0 forced to zero.
- R2: An align-address operation writes bits 2:0 of the sum into status bits 2:0 and leaves status bits 7:3 unchanged.
- R3: An extract operation (`in_op` = 1) with status offset k in 1..7 returns (`in_a` << 8k) | (`in_b` >> (64 - 8k)).
- R4: An extract with status offset 0 returns `in_a` exactly, and `in_b` has no effect on the result.
- R5: An extract uses the offset written by the most recent align-address. This holds when the extract is issued in the cycle directly after it.
- R6: While `tst_we` is high, the whole status register is loaded from `tst_wdata` at the next edge. This takes precedence over an align-address in the same cycle. `status_q` always shows the register.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `out_result` is updated at that edge. Without `in_valid`, `out_result` holds its value.
- R8: Synchronous reset clears the status register, `out_result` and `out_valid` to zero.
- R9: An extract operation leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 = align-address, 1 = extract |
| in_a | input | 64 | First operand (earlier bytes for extract) |
| in_b | input | 64 | Second operand |
| tst_we | input | 1 | Test load enable for the status register |
| tst_wdata | input | 8 | Test load value |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Registered result |
| status_q | output | 8 | Status register; bits 2:0 hold the byte offset |

## Verification
The bench builds the unit with its defaults: 64-bit data, 8-bit lanes and an 8-bit status register. With these values the offset has only eight values. Every offset can therefore be loaded through the test port and extracted with two distinct byte patterns. All 64 pairs of operand low bits are driven through the align-address path, together with a wrapping sum. The same settings keep the upper status bits visible, so the bench can confirm that neither operation disturbs them. Back-to-back address-then-extract pairs and a test load that collides with an align-address are also covered.

// File: rtl/bau_pkg.sv
package bau_pkg;
  typedef enum logic {
    OP_ALIGN_ADDR = 1'b0,
    OP_EXTRACT    = 1'b1
  } bau_op_e;
endpackage

// File: rtl/bau_addr_calc.sv
module bau_addr_calc #(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] aligned,
  output logic [OFS_W-1:0]  ofs
);
  logic [DATA_W-1:0] sum;

  assign sum     = a + b;
  assign ofs     = sum[OFS_W-1:0];
  assign aligned = {sum[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
endmodule

// File: rtl/bau_funnel.sv
module bau_funnel #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [OFS_W-1:0]  ofs,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] cand [LANES];

  // One candidate per offset. Offset 0 passes the first word through, so no
  // full-width shift exists anywhere in the selector.
  for (genvar k = 0; k < LANES; k++) begin : g_cand
    if (k == 0) begin : g_pass
      assign cand[k] = a;
    end else begin : g_join
      assign cand[k] = {a[DATA_W-1-k*LANE_W:0], b[DATA_W-1 -: k*LANE_W]};
    end
  end

  assign data = cand[ofs];

  initial begin
    assert (LANES == (1 << OFS_W)) else $error("lane count must be a power of two");
  end
endmodule

// File: rtl/bau_status_reg.sv
module bau_status_reg #(
  parameter int STATUS_W = 8,
  parameter int OFS_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tst_we,
  input  logic [STATUS_W-1:0] tst_wdata,
  input  logic                upd_en,
  input  logic [OFS_W-1:0]    upd_ofs,
  output logic [STATUS_W-1:0] status_q
);
  logic [STATUS_W-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (tst_we) begin
      status_d = tst_wdata;
    end else if (upd_en) begin
      status_d[OFS_W-1:0] = upd_ofs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  initial begin
    assert (STATUS_W > OFS_W) else $error("status register too narrow");
  end

  p_tst_load_r6: assert property (@(posedge clk) disable iff (rst)
    tst_we |=> status_q == $past(tst_wdata));

  p_ofs_update_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !tst_we) |=> status_q[OFS_W-1:0] == $past(upd_ofs));

  p_upper_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !tst_we) |=> status_q[STATUS_W-1:OFS_W] == $past(status_q[STATUS_W-1:OFS_W]));
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
  import bau_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int LANE_W   = 8,
  parameter int STATUS_W = 8,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int OFS_W   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_op,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic                tst_we,
  input  logic [STATUS_W-1:0] tst_wdata,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result,
  output logic [STATUS_W-1:0] status_q
);
  bau_op_e           op;
  logic [DATA_W-1:0] aligned;
  logic [OFS_W-1:0]  new_ofs;
  logic [DATA_W-1:0] extracted;
  logic              upd_en;
  bau_op_e           res_op_q;

  assign op     = bau_op_e'(in_op);
  assign upd_en = in_valid && (op == OP_ALIGN_ADDR);

  bau_addr_calc #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_addr (
    .a(in_a), .b(in_b), .aligned(aligned), .ofs(new_ofs)
  );

  // The status register is written at the same edge as the result, so an
  // extract in the next cycle already reads the new offset.
  bau_funnel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_funnel (
    .a(in_a), .b(in_b), .ofs(status_q[OFS_W-1:0]), .data(extracted)
  );

  bau_status_reg #(.STATUS_W(STATUS_W), .OFS_W(OFS_W)) u_status (
    .clk(clk), .rst(rst), .tst_we(tst_we), .tst_wdata(tst_wdata),
    .upd_en(upd_en), .upd_ofs(new_ofs), .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      res_op_q   <= OP_ALIGN_ADDR;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= (op == OP_EXTRACT) ? extracted : aligned;
        res_op_q   <= op;
      end
    end
  end

  p_addr_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_op_q == OP_ALIGN_ADDR) |-> out_result[OFS_W-1:0] == '0);

  p_zero_ofs_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_EXTRACT && status_q[OFS_W-1:0] == '0) |=> out_result == $past(in_a));

  p_extract_keeps_status_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_EXTRACT && !tst_we) |=> $stable(status_q));

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));
endmodule

// File: tb/tb_byte_align_unit.sv
module tb_byte_align_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        tst_we = 1'b0;
  logic [7:0]  tst_wdata = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [7:0]  status_q;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model_st;

  always #5 clk = ~clk;

  byte_align_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .tst_we(tst_we), .tst_wdata(tst_wdata),
    .out_valid(out_valid), .out_result(out_result), .status_q(status_q)
  );

  function automatic logic [63:0] exp_ext(logic [63:0] a, logic [63:0] b, int k);
    if (k == 0) return a;
    return (a << (8 * k)) | (b >> (64 - 8 * k));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation at a falling edge; outputs are read at the next one.
  task automatic run_op(logic op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tst_load(logic [7:0] v);
    @(negedge clk);
    tst_we = 1'b1; tst_wdata = v;
    @(negedge clk);
    tst_we = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, s, pa, pb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R8 out_result", out_result, 64'd0);
    chk("R8 status", {56'd0, status_q}, 64'd0);

    // R6 test load and readback
    tst_load(8'hA5);
    chk("R6 load", {56'd0, status_q}, 64'h00A5);
    model_st = 8'hA5;

    // R1/R2 sweep of operand low bits
    for (int la = 0; la < 8; la++) begin
      for (int lb = 0; lb < 8; lb++) begin
        a = {61'h0123_4567_89AB_CDE >> 0, 3'(la)} ^ (64'(la) << 40);
        b = {61'h0FED_CBA9_8765_432, 3'(lb)};
        s = a + b;
        run_op(1'b0, a, b);
        model_st = {model_st[7:3], s[2:0]};
        chk("R1 aligned sum", out_result, {s[63:3], 3'b000});
        chk("R2 status", {56'd0, status_q}, {56'd0, model_st});
        chk("R7 out_valid", {63'd0, out_valid}, 64'd1);
      end
    end

    // R1 wrap-around
    run_op(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h6);
    model_st = {model_st[7:3], 3'd5};
    chk("R1 wrap", out_result, 64'h0);
    chk("R2 wrap status", {56'd0, status_q}, {56'd0, model_st});

    // R7 idle: valid drops, result holds
    @(negedge clk);
    chk("R7 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R7 idle hold", out_result, 64'h0);

    // R3/R4/R9 every offset, two patterns
    for (int k = 0; k < 8; k++) begin
      tst_load({5'b01010, 3'(k)});
      pa = 64'h0011_2233_4455_6677; pb = 64'h8899_AABB_CCDD_EEFF;
      run_op(1'b1, pa, pb);
      chk(k == 0 ? "R4 offset zero" : "R3 extract", out_result, exp_ext(pa, pb, k));
      chk("R9 status kept", {56'd0, status_q}, {56'd0, 5'b01010, 3'(k)});
      pa = 64'hF0E1_D2C3_B4A5_9687; pb = 64'hFFFF_FFFF_FFFF_FFFF;
      run_op(1'b1, pa, pb);
      chk(k == 0 ? "R4 b ignored" : "R3 extract p2", out_result, exp_ext(pa, pb, k));
    end

    // R5 back-to-back align then extract
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_op = 1'b0; in_a = 64'h1000; in_b = 64'(k);
      @(negedge clk);
      chk("R5 addr result", out_result, 64'h1000);
      pa = 64'hA1A2_A3A4_A5A6_A7A8; pb = 64'hB1B2_B3B4_B5B6_B7B8;
      in_op = 1'b1; in_a = pa; in_b = pb;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R5 extract new offset", out_result, exp_ext(pa, pb, k));
    end

    // R6 test load wins over align in the same cycle
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b0; in_a = 64'h3; in_b = 64'h0;
    tst_we = 1'b1; tst_wdata = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0; tst_we = 1'b0;
    chk("R6 precedence", {56'd0, status_q}, 64'h3C);
    chk("R1 result under load", out_result, 64'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule